// File: doc/BRIEF.md
# Flow-tuple keyed XOR hash engine

This block turns a fourteen-dword flow descriptor into the two hash values a packet classifier needs when it installs or looks up a filter. The first descriptor dword carries the flow-type, pool and VLAN bits. The other thirteen dwords carry the addresses, ports and flex bytes. The block returns a bucket index, which selects a row in the filter table, and a combined 32-bit word. That word holds either a signature or a software index in its upper half, and the bucket in its lower half.

The hash is a keyed XOR fold. It is not a CRC and not a Toeplitz hash. Dwords 1 to 13 are XORed into one common dword, and a copy with its halves swapped is made. The flow/pool/VLAN dword is then mixed into the two copies at different points in the sequence. Each key bit pair (i, i+16) chooses whether a copy shifted right by i bits joins the result. Two independent 32-bit keys are applied: one for the bucket and one for the signature. The table-size setting and the match mode together set how many bucket bits are kept.

A job is offered with a valid/ready handshake. When the job is accepted, the result is registered and is presented one clock later. Descriptor dwords are taken in host bit order; any byte swapping is done by whoever builds the descriptor.

Top module: `fth_engine`

## Requirements
- R1: The common dword is the XOR of descriptor dwords 1 to 13. Dword 0 takes no part in this fold. With only key bit 0 set, the raw hash does not depend on dword 0.
- R2: The high working dword is the common dword XOR d0 XOR (d0 >> 16), where d0 is descriptor dword 0. The low working dword starts as the common dword with its 16-bit halves exchanged.
- R3: Key bit 0 XORs the unshifted low working dword into the raw hash, taken before any d0 contribution. Key bit 16 XORs the unshifted high working dword into the raw hash.
- R4: For i from 1 to 15, the low working dword is first XORed with d0 XOR (d0 << 16). Key bit i then XORs (low >> i) into the raw hash, and key bit i+16 XORs (high >> i). Shifts are logical.
- R5: In signature mode (perfect_mode = 0), out_bucket keeps the low 13, 14 or 15 bits of the raw bucket hash for table_size 0, 1 or 2. Code 3 behaves like code 0. All higher bits of out_bucket are zero.
- R6: In perfect mode (perfect_mode = 1), out_bucket keeps the low 11, 12 or 13 bits for table_size 0, 1 or 2. Code 3 behaves like code 0.
- R7: out_hash[15:0] equals out_bucket. In signature mode, out_hash[31:16] is bits 15:0 of the raw hash computed with sig_key; the raw hash is not masked before this use. In perfect mode, out_hash[31:16] is sw_index.
- R8: A job is accepted on a clock edge where in_valid and in_ready are both 1, and out_valid is 1 after that edge. in_ready equals !out_valid || out_ready.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_bucket and out_hash stay unchanged.
- R10: Synchronous active-high reset clears out_valid. in_ready is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A job is offered |
| in_ready | output | 1 | The block can take a job this cycle |
| in_desc | input | 448 | Descriptor; dword k is at bits 32k+31:32k, dword 0 is flow/pool/VLAN |
| perfect_mode | input | 1 | 0 = signature mode, 1 = perfect mode |
| table_size | input | 2 | 0 small, 1 medium, 2 large, 3 treated as small |
| sw_index | input | 16 | Software index placed in the upper half in perfect mode |
| bucket_key | input | 32 | Key for the bucket hash |
| sig_key | input | 32 | Key for the signature hash |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_bucket | output | 16 | Masked bucket index |
| out_hash | output | 32 | Combined word: upper half signature or index, lower half bucket |

## Verification
The properties assume that the consumer follows the handshake rules. They also assume that perfect_mode, table_size and sw_index are meaningful only in the cycle a job is accepted, so the checker keeps its own copy of those settings taken at acceptance. The bench changes configuration only while in_valid is driven, and it holds in_valid until in_ready is seen. It stalls out_ready in irregular patterns so that the hold and backpressure rules are exercised. Directed jobs use single-bit and paired keys to isolate each stage of the fold. Pseudo-random jobs cover all four table_size codes in both modes.

// File: rtl/fth_pkg.sv
package fth_pkg;

    localparam int unsigned DW         = 32;
    localparam int unsigned HW         = DW / 2;
    localparam int unsigned NDW        = 14;
    localparam int unsigned DESC_W     = NDW * DW;
    localparam int unsigned SIG_BASE_W = 13;
    localparam int unsigned PRF_BASE_W = 11;

    typedef enum logic [1:0] {
        TBL_SMALL = 2'd0,
        TBL_MED   = 2'd1,
        TBL_LARGE = 2'd2,
        TBL_RSVD  = 2'd3
    } tbl_size_e;

    typedef enum logic {
        MODE_SIG  = 1'b0,
        MODE_PERF = 1'b1
    } match_mode_e;

    typedef struct packed {
        match_mode_e      mode;
        tbl_size_e        size;
        logic [HW-1:0]    sw_index;
    } job_cfg_t;

    typedef struct packed {
        logic [HW-1:0]    bucket;
        logic [DW-1:0]    word;
    } hash_res_t;

    // number of bucket bits kept for a mode / table-size pair
    function automatic int unsigned bucket_width(match_mode_e m, tbl_size_e s);
        int unsigned step;
        case (s)
            TBL_MED:   step = 1;
            TBL_LARGE: step = 2;
            default:   step = 0;
        endcase
        return ((m == MODE_PERF) ? PRF_BASE_W : SIG_BASE_W) + step;
    endfunction

    function automatic logic [HW-1:0] low_mask(int unsigned w);
        logic [HW-1:0] m;
        for (int unsigned i = 0; i < HW; i++) begin
            m[i] = (i < w);
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] swap_halves(logic [DW-1:0] x);
        return {x[HW-1:0], x[DW-1:HW]};
    endfunction

endpackage

// File: rtl/fth_fold.sv
// XOR of descriptor dwords 1 .. NDW-1; dword 0 is left out.
module fth_fold #(
    parameter int unsigned DW  = 32,
    parameter int unsigned NDW = 14,
    localparam int unsigned DESC_W = NDW * DW
) (
    input  logic [DESC_W-1:0] desc,
    output logic [DW-1:0]     common,
    output logic [DW-1:0]     flow_dw
);

    logic [DW-1:0] chain [NDW];

    assign chain[0] = '0;

    for (genvar k = 1; k < NDW; k++) begin : g_chain
        assign chain[k] = chain[k-1] ^ desc[k*DW +: DW];
    end

    assign common  = chain[NDW-1];
    assign flow_dw = desc[DW-1:0];

endmodule

// File: rtl/fth_keyed.sv
// Keyed combination of the working dwords for one key.
module fth_keyed #(
    parameter int unsigned DW = 32,
    localparam int unsigned HW = DW / 2
) (
    input  logic [DW-1:0] common,
    input  logic [DW-1:0] flow_dw,
    input  logic [DW-1:0] key,
    output logic [DW-1:0] raw
);
    import fth_pkg::swap_halves;

    logic [DW-1:0] hi_w;
    logic [DW-1:0] lo_early;
    logic [DW-1:0] lo_late;
    logic [DW-1:0] lo_term [HW];
    logic [DW-1:0] hi_term [HW];

    // high copy gets the flow dword folded down before any key bit
    assign hi_w     = common ^ flow_dw ^ (flow_dw >> HW);
    // low copy: swapped halves; flow dword folded up only after bit 0
    assign lo_early = swap_halves(common);
    assign lo_late  = lo_early ^ flow_dw ^ (flow_dw << HW);

    for (genvar i = 0; i < HW; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign lo_term[i] = key[0]  ? lo_early : '0;
            assign hi_term[i] = key[HW] ? hi_w     : '0;
        end else begin : g_rest
            assign lo_term[i] = key[i]      ? (lo_late >> i) : '0;
            assign hi_term[i] = key[i + HW] ? (hi_w    >> i) : '0;
        end
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < HW; i++) begin
            raw = raw ^ lo_term[i] ^ hi_term[i];
        end
    end

endmodule

// File: rtl/fth_pack.sv
// Bucket masking and assembly of the combined word.
module fth_pack
    import fth_pkg::*;
(
    input  job_cfg_t       cfg,
    input  logic [HW-1:0]  bkt_low,
    input  logic [HW-1:0]  sig_low,
    output hash_res_t      res
);

    logic [HW-1:0] keep;
    logic [HW-1:0] bucket;
    logic [HW-1:0] upper;

    assign keep   = low_mask(bucket_width(cfg.mode, cfg.size));
    assign bucket = bkt_low & keep;
    assign upper  = (cfg.mode == MODE_PERF) ? cfg.sw_index : sig_low;

    assign res.bucket = bucket;
    assign res.word   = {upper, bucket};

endmodule

// File: rtl/fth_engine.sv
module fth_engine
    import fth_pkg::*;
#(
    parameter int unsigned WORD_W  = fth_pkg::DW,
    parameter int unsigned N_WORDS = fth_pkg::NDW,
    localparam int unsigned HALF_W = WORD_W / 2,
    localparam int unsigned IN_W   = WORD_W * N_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_W-1:0]   in_desc,
    input  logic              perfect_mode,
    input  logic [1:0]        table_size,
    input  logic [HALF_W-1:0] sw_index,
    input  logic [WORD_W-1:0] bucket_key,
    input  logic [WORD_W-1:0] sig_key,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HALF_W-1:0] out_bucket,
    output logic [WORD_W-1:0] out_hash
);

    logic [WORD_W-1:0] common;
    logic [WORD_W-1:0] flow_dw;
    logic [WORD_W-1:0] bkt_raw;
    logic [WORD_W-1:0] sig_raw;
    job_cfg_t          cfg;
    hash_res_t         res_next;
    hash_res_t         res_q;
    logic              valid_q;
    logic              accept;
    logic              unused_raw_hi;

    fth_fold #(.DW(WORD_W), .NDW(N_WORDS)) u_fold (
        .desc    (in_desc),
        .common  (common),
        .flow_dw (flow_dw)
    );

    fth_keyed #(.DW(WORD_W)) u_bkt (
        .common  (common),
        .flow_dw (flow_dw),
        .key     (bucket_key),
        .raw     (bkt_raw)
    );

    fth_keyed #(.DW(WORD_W)) u_sig (
        .common  (common),
        .flow_dw (flow_dw),
        .key     (sig_key),
        .raw     (sig_raw)
    );

    assign cfg.mode     = match_mode_e'(perfect_mode);
    assign cfg.size     = tbl_size_e'(table_size);
    assign cfg.sw_index = sw_index;

    fth_pack u_pack (
        .cfg     (cfg),
        .bkt_low (bkt_raw[HALF_W-1:0]),
        .sig_low (sig_raw[HALF_W-1:0]),
        .res     (res_next)
    );

    // upper raw bits never reach an output after masking
    assign unused_raw_hi = ^{bkt_raw[WORD_W-1:HALF_W], sig_raw[WORD_W-1:HALF_W]};

    assign in_ready = !valid_q || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (accept) begin
            valid_q <= 1'b1;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            res_q <= res_next;
        end
    end

    assign out_valid  = valid_q;
    assign out_bucket = res_q.bucket;
    assign out_hash   = res_q.word;

endmodule

// File: rtl/fth_engine_chk.sv
module fth_engine_chk
    import fth_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          perfect_mode,
    input logic [1:0]    table_size,
    input logic [HW-1:0] sw_index,
    input logic          out_valid,
    input logic          out_ready,
    input logic [HW-1:0] out_bucket,
    input logic [DW-1:0] out_hash
);

    logic          cap_perf;
    logic [1:0]    cap_size;
    logic [HW-1:0] cap_idx;
    logic [HW-1:0] cap_keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_perf <= 1'b0;
            cap_size <= 2'd0;
            cap_idx  <= '0;
        end else if (in_valid && in_ready) begin
            cap_perf <= perfect_mode;
            cap_size <= table_size;
            cap_idx  <= sw_index;
        end
    end

    assign cap_keep = low_mask(bucket_width(match_mode_e'(cap_perf), tbl_size_e'(cap_size)));

    // R5 / R6: no bucket bit above the width chosen at acceptance
    a_r5_bucket_width: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_bucket & ~cap_keep) == '0));

    // R6: perfect mode leaves out_bucket[15:13] clear at most
    a_r6_perfect_narrow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cap_perf) |-> (out_bucket[HW-1:13] == '0));

    // R7: lower half of the combined word mirrors the bucket
    a_r7_low_half: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_hash[HW-1:0] == out_bucket));

    // R7: index in the upper half in perfect mode
    a_r7_index_upper: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cap_perf) |-> (out_hash[DW-1:HW] == cap_idx));

    // R8: accepted job shows up on the next cycle
    a_r8_accept_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R8: idle output stage always takes a job
    a_r8_idle_ready: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R9: stalled result is held
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hash) && $stable(out_bucket)));

    // R10: reset empties the output stage
    a_r10_reset_empty: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind fth_engine fth_engine_chk u_fth_engine_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .perfect_mode (perfect_mode),
    .table_size   (table_size),
    .sw_index     (sw_index),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_bucket   (out_bucket),
    .out_hash     (out_hash)
);

// File: tb/test_fth_engine.sv
`timescale 1ns/1ps
module test_fth_engine;

    localparam int DWB = 32;
    localparam int NW  = 14;
    localparam int DBW = DWB * NW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [DBW-1:0] in_desc = '0;
    logic           perfect_mode = 1'b0;
    logic [1:0]     table_size = 2'd0;
    logic [15:0]    sw_index = '0;
    logic [31:0]    bucket_key = '0;
    logic [31:0]    sig_key = '0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [15:0]    out_bucket;
    logic [31:0]    out_hash;

    int tests = 0;
    int fails = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;
    int cyc = 0;
    logic [31:0] rng = 32'h1234_5679;

    logic [47:0] exp_q [$];
    string       tag_q [$];

    fth_engine i_fth_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .perfect_mode(perfect_mode), .table_size(table_size),
        .sw_index(sw_index), .bucket_key(bucket_key), .sig_key(sig_key),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_bucket(out_bucket), .out_hash(out_hash)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // model written from the requirement text
    function automatic logic [31:0] model_raw(logic [DBW-1:0] d, logic [31:0] k);
        logic [31:0] c, hi, lo, r, f;
        c = '0;
        for (int n = 1; n < NW; n++) c = c ^ d[n*32 +: 32];
        f  = d[31:0];
        hi = c ^ f ^ (f >> 16);
        lo = {c[15:0], c[31:16]};
        r  = '0;
        if (k[0])  r = r ^ lo;
        if (k[16]) r = r ^ hi;
        lo = lo ^ f ^ (f << 16);
        for (int i = 15; i >= 1; i--) begin
            if (k[i])      r = r ^ (lo >> i);
            if (k[i + 16]) r = r ^ (hi >> i);
        end
        return r;
    endfunction

    function automatic int keep_bits(logic perf, logic [1:0] sz);
        int base;
        base = perf ? 11 : 13;
        if (sz == 2'd1) return base + 1;
        if (sz == 2'd2) return base + 2;
        return base;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [DBW-1:0] d, logic perf, logic [1:0] sz, logic [15:0] idx,
                        logic [31:0] bk, logic [31:0] sk, string tag);
        logic [31:0] rb, rs;
        logic [15:0] eb, up;
        rb = model_raw(d, bk);
        rs = model_raw(d, sk);
        eb = 16'(rb & ((32'd1 << keep_bits(perf, sz)) - 32'd1));
        up = perf ? idx : rs[15:0];
        @(negedge clk);
        in_valid = 1'b1; in_desc = d; perfect_mode = perf; table_size = sz;
        sw_index = idx; bucket_key = bk; sig_key = sk;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({eb, up, eb});
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    function automatic logic [DBW-1:0] rand_desc(inout logic [31:0] s);
        logic [DBW-1:0] d;
        for (int n = 0; n < NW; n++) begin
            s = next_rng(s);
            d[n*32 +: 32] = s;
        end
        return d;
    endfunction

    // out_ready changes shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            cyc++;
            out_ready = stall_en ? ((cyc % 4 != 1) && (cyc % 7 != 0)) : 1'b1;
        end
    end

    // scoreboard monitor
    initial begin
        logic [47:0] e;
        string t;
        bit prev_stall;
        logic [15:0] pb;
        logic [31:0] ph;
        prev_stall = 1'b0;
        pb = '0; ph = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_stall) begin
                    check(out_valid && out_bucket == pb && out_hash == ph, "R9",
                          "held result", {out_bucket, out_hash}, {pb, ph});
                end
                if (out_valid && !out_ready) begin
                    check(!in_ready, "R8", "ready while stalled", 64'(in_ready), 64'd0);
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected result", {out_bucket, out_hash}, 64'd0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_bucket == e[47:32], t, "bucket", 64'(out_bucket), 64'(e[47:32]));
                        check(out_hash == e[31:0], t, "combined word", 64'(out_hash), 64'(e[31:0]));
                    end
                end
                prev_stall = out_valid && !out_ready;
                pb = out_bucket;
                ph = out_hash;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [DBW-1:0] d, d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        check(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

        d = rand_desc(rng);
        d2 = d;
        d2[31:0] = ~d[31:0];
        // R1: dword 0 has no effect with only key bit 0
        send(d,  1'b0, 2'd2, 16'h0, 32'h0000_0001, 32'h0000_0001, "R1");
        send(d2, 1'b0, 2'd2, 16'h0, 32'h0000_0001, 32'h0000_0001, "R1");
        // R2: high copy with d0 folded down via key bit 16
        send(d,  1'b0, 2'd2, 16'h0, 32'h0001_0000, 32'h0001_0000, "R2");
        send(d2, 1'b0, 2'd2, 16'h0, 32'h0001_0000, 32'h0001_0000, "R2");
        // R3: bits 0 and 16 together
        send(d,  1'b0, 2'd1, 16'h0, 32'h0001_0001, 32'h0001_0001, "R3");
        // R4: single shifted lanes and paired lanes
        send(d,  1'b0, 2'd2, 16'h0, 32'h0000_0020, 32'h0020_0000, "R4");
        send(d2, 1'b0, 2'd2, 16'h0, 32'h0000_8000, 32'h8000_0000, "R4");
        send(d,  1'b0, 2'd2, 16'h0, 32'h0002_0002, 32'hFFFF_FFFF, "R4");
        // R5: every size code in signature mode
        for (int s = 0; s < 4; s++)
            send(d, 1'b0, 2'(s), 16'h0, 32'hFFFF_FFFF, 32'h3D2E_8A51, "R5");
        // R6: every size code in perfect mode
        for (int s = 0; s < 4; s++)
            send(d, 1'b1, 2'(s), 16'hA5C3, 32'hFFFF_FFFF, 32'h3D2E_8A51, "R6");
        // R7: index values at the edges
        send(d2, 1'b1, 2'd2, 16'hFFFF, 32'h5A5A_A5A5, 32'h0, "R7");
        send(d2, 1'b1, 2'd0, 16'h0000, 32'h5A5A_A5A5, 32'h0, "R7");
        send(d2, 1'b0, 2'd0, 16'hFFFF, 32'h5A5A_A5A5, 32'hC3C3_0F0F, "R7");

        // R8 / R9: back-to-back traffic under backpressure
        stall_en = 1'b1;
        for (int n = 0; n < 200; n++) begin
            logic [31:0] bk, sk;
            d = rand_desc(rng);
            rng = next_rng(rng); bk = rng;
            rng = next_rng(rng); sk = rng;
            send(d, rng[3], rng[5:4], rng[31:16], bk, sk, "R8");
        end
        @(negedge clk);
        in_valid = 1'b0;
        stall_en = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "drained", 64'(out_valid), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule